// File: doc/BRIEF.md
# JTAG In-System Flash Command Controller

This block is the target-side command engine that sits behind a JTAG TAP controller and executes in-system configuration commands against a small sectored flash model. The TAP state machine is outside the block. It supplies one-cycle capture, shift and update strobes for both the instruction path and the data path. The block owns an 8-bit instruction register and a data chain whose length follows the current instruction. The data chain carries a status byte, a 32-bit identification value, an 8-bit address, a 64-bit program word, a 64-bit sector mask, the 64-bit option register or a 64-bit blank-check result.

The flash array is modelled only by its state. Each sector has an erased flag. There is also a 64-bit option register, which holds per-sector protect bits and configuration flags, and a security lock. Programming and erasing run for `BUSY_CYCLES` TCK cycles, and a host polls the status byte until the ready bit rises. Sectors of the low bank occupy mask bits from 0 upward. Sectors of the high bank occupy mask bits from 32 upward.

Top module: `isc_flash_ctrl`

## Requirements
- R1: After reset the status byte reads 0x04 and the instruction register holds IDCODE (0xFE). Under IDCODE, capture loads the 32-bit `ID_VALUE` parameter, and every data chain shifts out LSB first.
- R2: The instruction codes are IDCODE 0xFE, config read 0x07, enable 0x0C, disable 0x0F, address 0x11, clear status 0x13, program 0x20, program security 0x22, erase 0x30, blank check 0x60 and status read 0xE8. The status byte is {0, lock[6], int_err[5:4], mode[3], ready[2], code[1:0]}.
- R3: Any instruction other than IDCODE, status read and enable that is loaded while the mode bit is 0 sets code 3 and leaves the array, option register and address untouched.
- R4: Enable sets the mode bit and code 2. Disable, issued while the mode bit is set, clears the mode bit and sets code 2.
- R5: An unknown opcode sets code 1. Clear status sets code 0 and clears int_err. Status read and IDCODE leave the status byte unchanged.
- R6: Address loads an 8-bit value at update. Program, issued at a sector's mask position, marks that sector not blank. The ready bit reads 0 for BUSY_CYCLES cycles after the request, and code 2 is set on completion.
- R7: An erase mask bit at a sector's position (low bank i at bit i, high bank j at bit 32+j) re-erases that sector only.
- R8: Program or erase that touches a sector whose option bit is set fails with code 1 and changes no sector.
- R9: A program, erase or program-security request made while busy is dropped, sets code 1 and sets int_err to 01.
- R10: Program at address 0x50 writes the option register, but only when data bit 63 is 1; otherwise it sets code 1. Config read returns the option register.
- R11: An erase mask with only bit 49 set restores the option register to `OPT_RESET` and leaves sectors alone.
- R12: Program security at address 0x80 sets the lock bit 6. An all-ones erase mask erases every sector, clears the lock and restores the option register, even when sectors are protected.
- R13: Blank check takes a mask at update. The next capture returns a 64-bit value in which a set bit marks a selected sector that is not blank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| tdi | input | 1 | Serial data in for the instruction and data chains |
| tdo | output | 1 | Serial data out; instruction chain while shift_ir, else data chain |
| capture_ir | input | 1 | Load the fixed capture pattern into the instruction chain |
| shift_ir | input | 1 | Shift the instruction chain one bit |
| update_ir | input | 1 | Latch the shifted opcode and act on it |
| capture_dr | input | 1 | Load the selected data register into the data chain |
| shift_dr | input | 1 | Shift the data chain one bit |
| update_dr | input | 1 | Act on the shifted data for the current instruction |

## Verification
A table of commands is replayed while the mode is off, after enable, and against valid and invalid addresses. Each step is judged by the full status byte, which separates the gating, invalid and success codes. Sector state is read back only through blank check, under full and partial masks. This exposes whether erase and program hit the right mask position in each bank and whether protected sectors stayed unchanged. A request issued back to back with a running one separates the busy-rejection path from ordinary failures, through int_err and the low ready bit. Full erase is tried with protected sectors and a set lock, to show that it overrides both.

// File: rtl/isc_pkg.sv
`timescale 1ns/1ps
package isc_pkg;
   localparam int IR_W   = 8;
   localparam int MASK_W = 64;

   localparam logic [IR_W-1:0] OP_IDCODE   = 8'hFE;
   localparam logic [IR_W-1:0] OP_CFG_RD   = 8'h07;
   localparam logic [IR_W-1:0] OP_ENABLE   = 8'h0C;
   localparam logic [IR_W-1:0] OP_DISABLE  = 8'h0F;
   localparam logic [IR_W-1:0] OP_ADDR     = 8'h11;
   localparam logic [IR_W-1:0] OP_CLR      = 8'h13;
   localparam logic [IR_W-1:0] OP_PROG     = 8'h20;
   localparam logic [IR_W-1:0] OP_PROG_SEC = 8'h22;
   localparam logic [IR_W-1:0] OP_ERASE    = 8'h30;
   localparam logic [IR_W-1:0] OP_BLANK    = 8'h60;
   localparam logic [IR_W-1:0] OP_STATUS   = 8'hE8;

   localparam logic [1:0] RC_NONE    = 2'd0;
   localparam logic [1:0] RC_INVALID = 2'd1;
   localparam logic [1:0] RC_OK      = 2'd2;
   localparam logic [1:0] RC_OFF     = 2'd3;
   localparam logic [1:0] IE_NONE    = 2'd0;
   localparam logic [1:0] IE_BUSY    = 2'd1;

   localparam logic [7:0] ADDR_OPT = 8'h50;
   localparam logic [7:0] ADDR_SEC = 8'h80;
   localparam int         OPT_ONLY_BIT = 49;

   typedef enum logic [2:0] {
      DR_STATUS, DR_ID, DR_OPT, DR_ADDR, DR_WORD, DR_MASK, DR_BLANK
   } dr_sel_e;

   typedef enum logic [2:0] {
      K_PROG_SECT, K_PROG_OPT, K_SEC, K_ER_FULL, K_ER_OPT, K_ER_MASK
   } op_kind_e;

   typedef struct packed {
      dr_sel_e sel;
      logic    known;
      logic    gated;
   } ir_dec_t;

   function automatic ir_dec_t decode_op(input logic [IR_W-1:0] op);
      ir_dec_t d;
      d.sel   = DR_STATUS;
      d.known = 1'b1;
      d.gated = 1'b1;
      case (op)
         OP_IDCODE:  begin d.sel = DR_ID; d.gated = 1'b0; end
         OP_STATUS:  d.gated = 1'b0;
         OP_ENABLE:  d.gated = 1'b0;
         OP_CFG_RD:  d.sel = DR_OPT;
         OP_ADDR:    d.sel = DR_ADDR;
         OP_PROG:    d.sel = DR_WORD;
         OP_ERASE:   d.sel = DR_MASK;
         OP_BLANK:   d.sel = DR_BLANK;
         OP_DISABLE, OP_CLR, OP_PROG_SEC: d.sel = DR_STATUS;
         default:    begin d.known = 1'b0; d.gated = 1'b0; end
      endcase
      return d;
   endfunction

   function automatic int sector_pos(input int s, input int b0);
      return (s < b0) ? s : (32 + s - b0);
   endfunction

   function automatic logic [MASK_W-1:0] sector_map(input int b0, input int b1);
      logic [MASK_W-1:0] m;
      m = '0;
      for (int i = 0; i < b0; i++) m[i] = 1'b1;
      for (int j = 0; j < b1; j++) m[32 + j] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/isc_ir_unit.sv
`timescale 1ns/1ps
module isc_ir_unit
   import isc_pkg::*;
#(
   parameter logic [IR_W-1:0] RESET_OP    = OP_IDCODE,
   parameter logic [IR_W-1:0] CAPTURE_PAT = 8'h01
) (
   input  logic            tck,
   input  logic            rst_n,
   input  logic            tdi,
   input  logic            capture_ir,
   input  logic            shift_ir,
   input  logic            update_ir,
   output logic            tdo_ir,
   output logic [IR_W-1:0] op_next,
   output logic [IR_W-1:0] op_q
);
   logic [IR_W-1:0] sr_q;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
         op_q <= RESET_OP;
      end else begin
         if (capture_ir)    sr_q <= CAPTURE_PAT;
         else if (shift_ir) sr_q <= {tdi, sr_q[IR_W-1:1]};
         if (update_ir)     op_q <= sr_q;
      end
   end

   assign tdo_ir  = sr_q[0];
   assign op_next = sr_q;
endmodule

// File: rtl/isc_dr_chain.sv
`timescale 1ns/1ps
module isc_dr_chain #(
   parameter int W     = 64,
   parameter int LEN_W = $clog2(W + 1)
) (
   input  logic             tck,
   input  logic             rst_n,
   input  logic             tdi,
   input  logic             capture,
   input  logic             shift,
   input  logic [W-1:0]     cap_val,
   input  logic [LEN_W-1:0] len,
   output logic [W-1:0]     sr_q,
   output logic             tdo
);
   logic [W-1:0] shifted;

   generate
      if (W < 2) begin : g_bad_w
         $error("isc_dr_chain: W must be at least 2");
      end
   endgenerate

   // Serial input enters at bit len-1; bits above the active length stay zero.
   always_comb begin
      for (int i = 0; i < W; i++) begin
         if (i == int'(len) - 1)      shifted[i] = tdi;
         else if (i < int'(len) - 1)  shifted[i] = sr_q[(i + 1) % W];
         else                         shifted[i] = 1'b0;
      end
   end

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n)       sr_q <= '0;
      else if (capture) sr_q <= cap_val;
      else if (shift)   sr_q <= shifted;
   end

   assign tdo = sr_q[0];
endmodule

// File: rtl/isc_array_model.sv
`timescale 1ns/1ps
module isc_array_model
   import isc_pkg::*;
#(
   parameter int                BANK0_SECTORS = 8,
   parameter int                BANK1_SECTORS = 4,
   parameter int                BUSY_CYCLES   = 64,
   parameter logic [MASK_W-1:0] OPT_RESET     = 64'h8000_0000_0000_0000
) (
   input  logic              tck,
   input  logic              rst_n,
   input  logic              req_i,
   input  op_kind_e          kind_i,
   input  logic [MASK_W-1:0] data_i,
   input  logic [7:0]        addr_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [MASK_W-1:0] erased_o,
   output logic [MASK_W-1:0] opt_o,
   output logic              sec_o
);
   localparam int NSEC  = BANK0_SECTORS + BANK1_SECTORS;
   localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

   logic [CNT_W-1:0]  cnt_q;
   op_kind_e          kind_q;
   logic [MASK_W-1:0] data_q;
   logic [7:0]        addr_q;
   logic [NSEC-1:0]   er_flag;

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         kind_q <= K_PROG_SECT;
         data_q <= '0;
         addr_q <= '0;
      end else if (req_i) begin
         cnt_q  <= CNT_W'(BUSY_CYCLES);
         kind_q <= kind_i;
         data_q <= data_i;
         addr_q <= addr_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o = (cnt_q != '0);
   assign done_o = (cnt_q == CNT_W'(1));

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         opt_o <= OPT_RESET;
         sec_o <= 1'b0;
      end else if (done_o) begin
         case (kind_q)
            K_PROG_OPT: opt_o <= data_q;
            K_SEC:      sec_o <= 1'b1;
            K_ER_FULL:  begin opt_o <= OPT_RESET; sec_o <= 1'b0; end
            K_ER_OPT:   opt_o <= OPT_RESET;
            default:    ;
         endcase
      end
   end

   generate
      for (genvar s = 0; s < NSEC; s++) begin : g_sect
         localparam int POS = sector_pos(s, BANK0_SECTORS);
         logic er_q;
         always_ff @(posedge tck or negedge rst_n) begin
            if (!rst_n) begin
               er_q <= 1'b1;
            end else if (done_o) begin
               if (kind_q == K_ER_FULL || (kind_q == K_ER_MASK && data_q[POS]))
                  er_q <= 1'b1;
               else if (kind_q == K_PROG_SECT && addr_q == 8'(POS))
                  er_q <= 1'b0;
            end
         end
         assign er_flag[s] = er_q;
      end
   endgenerate

   always_comb begin
      erased_o = '0;
      for (int s = 0; s < NSEC; s++) erased_o[sector_pos(s, BANK0_SECTORS)] = er_flag[s];
   end

   AST_REQ_WHEN_IDLE: assert property (@(posedge tck) disable iff (!rst_n)
      req_i |-> !busy_o) else $error("request accepted while busy"); // R9
   AST_BUSY_AFTER_REQ: assert property (@(posedge tck) disable iff (!rst_n)
      req_i |=> busy_o) else $error("no busy window after request"); // R6
   AST_OPT_TOP_SET: assert property (@(posedge tck) disable iff (!rst_n)
      opt_o[MASK_W-1]) else $error("option bit 63 cleared"); // R10
   AST_PROG_UNPROT: assert property (@(posedge tck) disable iff (!rst_n)
      (done_o && kind_q == K_PROG_SECT) |-> !opt_o[addr_q[5:0]])
      else $error("protected sector programmed"); // R8
endmodule

// File: rtl/isc_flash_ctrl.sv
`timescale 1ns/1ps
module isc_flash_ctrl
   import isc_pkg::*;
#(
   parameter int                BANK0_SECTORS = 8,
   parameter int                BANK1_SECTORS = 4,
   parameter int                BUSY_CYCLES   = 64,
   parameter logic [31:0]       ID_VALUE      = 32'h0A5C_1041,
   parameter logic [MASK_W-1:0] OPT_RESET     = 64'h8000_0000_0000_0000
) (
   input  logic tck,
   input  logic rst_n,
   input  logic tdi,
   output logic tdo,
   input  logic capture_ir,
   input  logic shift_ir,
   input  logic update_ir,
   input  logic capture_dr,
   input  logic shift_dr,
   input  logic update_dr
);
   localparam int                LEN_W = $clog2(MASK_W + 1);
   localparam logic [MASK_W-1:0] SMAP  = sector_map(BANK0_SECTORS, BANK1_SECTORS);
   localparam logic [MASK_W-1:0] OPT_ONLY = MASK_W'(1) << OPT_ONLY_BIT;

   generate
      if (BANK0_SECTORS < 1 || BANK0_SECTORS > 32) begin : g_bad_b0
         $error("BANK0_SECTORS must lie in 1..32");
      end
      if (BANK1_SECTORS < 0 || BANK1_SECTORS > 16) begin : g_bad_b1
         $error("BANK1_SECTORS must lie in 0..16");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
      if (OPT_RESET[MASK_W-1] != 1'b1) begin : g_bad_opt
         $error("OPT_RESET bit 63 must be 1");
      end
   endgenerate

   logic [IR_W-1:0]   ir_next, op_q;
   ir_dec_t           nxt, cur;
   logic              tdo_ir, tdo_dr;
   logic              mode_q;
   logic [1:0]        rc_q, ie_q;
   logic [7:0]        addr_q, status;
   logic [MASK_W-1:0] bc_q, dr_q, cap_val, opt_q, erased;
   logic [LEN_W-1:0]  len;
   logic              busy, done, sec, req, rej_busy, rej_bad, allow_dr;
   logic              addr_is_sect;
   op_kind_e          kind;

   isc_ir_unit u_ir (
      .tck(tck), .rst_n(rst_n), .tdi(tdi), .capture_ir(capture_ir),
      .shift_ir(shift_ir), .update_ir(update_ir), .tdo_ir(tdo_ir),
      .op_next(ir_next), .op_q(op_q)
   );

   assign nxt = decode_op(ir_next);
   assign cur = decode_op(op_q);
   assign status = {1'b0, sec, ie_q, mode_q, ~busy, rc_q};
   assign allow_dr = update_dr && cur.known && (!cur.gated || mode_q);
   assign addr_is_sect = (int'(addr_q) < BANK0_SECTORS) ||
                         (int'(addr_q) >= 32 && int'(addr_q) < 32 + BANK1_SECTORS);

   always_comb begin
      cap_val = '0;
      len     = LEN_W'(8);
      case (cur.sel)
         DR_STATUS: cap_val = {56'b0, status};
         DR_ID:     begin cap_val = {32'b0, ID_VALUE}; len = LEN_W'(32); end
         DR_OPT:    begin cap_val = opt_q; len = LEN_W'(MASK_W); end
         DR_ADDR:   cap_val = {56'b0, addr_q};
         DR_BLANK:  begin cap_val = bc_q; len = LEN_W'(MASK_W); end
         default:   len = LEN_W'(MASK_W);
      endcase
      if (cur.gated && !mode_q) cap_val = '0;
   end

   isc_dr_chain #(.W(MASK_W), .LEN_W(LEN_W)) u_dr (
      .tck(tck), .rst_n(rst_n), .tdi(tdi), .capture(capture_dr),
      .shift(shift_dr), .cap_val(cap_val), .len(len), .sr_q(dr_q), .tdo(tdo_dr)
   );

   assign tdo = shift_ir ? tdo_ir : tdo_dr;

   // Request arbitration: busy rejection beats every other outcome.
   always_comb begin
      req      = 1'b0;
      kind     = K_PROG_SECT;
      rej_busy = 1'b0;
      rej_bad  = 1'b0;
      if (update_ir && ir_next == OP_PROG_SEC && mode_q) begin
         if (busy)                    rej_busy = 1'b1;
         else if (addr_q != ADDR_SEC) rej_bad  = 1'b1;
         else begin req = 1'b1; kind = K_SEC; end
      end
      if (allow_dr && op_q == OP_PROG) begin
         if (busy) rej_busy = 1'b1;
         else if (addr_q == ADDR_OPT) begin
            if (dr_q[MASK_W-1]) begin req = 1'b1; kind = K_PROG_OPT; end
            else                rej_bad = 1'b1;
         end else if (addr_is_sect && !opt_q[addr_q[5:0]]) begin
            req = 1'b1; kind = K_PROG_SECT;
         end else rej_bad = 1'b1;
      end
      if (allow_dr && op_q == OP_ERASE) begin
         if (busy)                             rej_busy = 1'b1;
         else if (&dr_q)                       begin req = 1'b1; kind = K_ER_FULL; end
         else if (dr_q == OPT_ONLY)            begin req = 1'b1; kind = K_ER_OPT;  end
         else if (|(dr_q & SMAP & opt_q))      rej_bad = 1'b1;
         else                                  begin req = 1'b1; kind = K_ER_MASK; end
      end
   end

   isc_array_model #(
      .BANK0_SECTORS(BANK0_SECTORS), .BANK1_SECTORS(BANK1_SECTORS),
      .BUSY_CYCLES(BUSY_CYCLES), .OPT_RESET(OPT_RESET)
   ) u_array (
      .tck(tck), .rst_n(rst_n), .req_i(req), .kind_i(kind), .data_i(dr_q),
      .addr_i(addr_q), .busy_o(busy), .done_o(done), .erased_o(erased),
      .opt_o(opt_q), .sec_o(sec)
   );

   always_ff @(posedge tck or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 1'b0;
         rc_q   <= RC_NONE;
         ie_q   <= IE_NONE;
         addr_q <= '0;
         bc_q   <= '0;
      end else begin
         if (done) rc_q <= RC_OK;
         if (update_ir) begin
            if (!nxt.known) rc_q <= RC_INVALID;
            else if (ir_next == OP_ENABLE) begin
               mode_q <= 1'b1;
               rc_q   <= RC_OK;
            end else if (nxt.gated) begin
               if (!mode_q) rc_q <= RC_OFF;
               else if (ir_next == OP_DISABLE) begin
                  mode_q <= 1'b0;
                  rc_q   <= RC_OK;
               end else if (ir_next == OP_CLR) begin
                  rc_q <= RC_NONE;
                  ie_q <= IE_NONE;
               end else rc_q <= RC_OK;
            end
         end
         if (allow_dr && op_q == OP_ADDR)  addr_q <= dr_q[7:0];
         if (allow_dr && op_q == OP_BLANK) bc_q   <= dr_q & SMAP & ~erased;
         if (rej_busy) begin
            rc_q <= RC_INVALID;
            ie_q <= IE_BUSY;
         end else if (rej_bad) begin
            rc_q <= RC_INVALID;
         end
      end
   end

   AST_REQ_IN_MODE: assert property (@(posedge tck) disable iff (!rst_n)
      req |-> mode_q) else $error("array request outside ISC mode"); // R3
   AST_OFF_CODE: assert property (@(posedge tck) disable iff (!rst_n)
      (update_ir && nxt.gated && !mode_q) |=> (rc_q == RC_OFF))
      else $error("gated opcode while off did not report code 3"); // R3
   AST_BUSY_FLAG: assert property (@(posedge tck) disable iff (!rst_n)
      rej_busy |=> (ie_q == IE_BUSY && rc_q == RC_INVALID))
      else $error("busy rejection not flagged"); // R9
endmodule

// File: tb/isc_flash_ctrl_tb.sv
`timescale 1ns/1ps
module isc_flash_ctrl_tb;
   localparam int          B0   = 4;
   localparam int          B1   = 4;
   localparam int          BUSY = 100;
   localparam logic [31:0] IDV  = 32'h1A2B_3C4D;
   localparam logic [63:0] ORST = 64'h8000_0000_0000_0000;
   localparam logic [63:0] SMAP = 64'h0000_000F_0000_000F;

   localparam logic [7:0] C_ID = 8'hFE, C_CFG = 8'h07, C_EN = 8'h0C, C_DIS = 8'h0F,
                          C_ADR = 8'h11, C_CLR = 8'h13, C_PRG = 8'h20, C_SEC = 8'h22,
                          C_ERS = 8'h30, C_BLK = 8'h60, C_STS = 8'hE8;

   typedef struct packed {
      logic [7:0]  op;
      logic [7:0]  len;
      logic [63:0] data;
      logic [7:0]  exp;
   } vec_t;

   // Command table: status byte expected once the command has settled.
   localparam vec_t VEC [10] = '{
      '{C_ADR, 8'd8,  64'h1,          8'h07},  // address while off -> code 3
      '{C_EN,  8'd0,  64'h0,          8'h0E},  // enable
      '{C_ADR, 8'd8,  64'h1,          8'h0E},  // address sector 1
      '{C_PRG, 8'd64, 64'h1234_5678,  8'h0E},  // program sector 1
      '{C_ADR, 8'd8,  64'hFF,         8'h0E},  // address nowhere
      '{C_PRG, 8'd64, 64'h9,          8'h0D},  // program bad address -> code 1
      '{C_CLR, 8'd0,  64'h0,          8'h0C},  // clear status
      '{C_ERS - 8'h30 + 8'h55, 8'd0, 64'h0, 8'h0D},  // unknown opcode 0x55
      '{C_DIS, 8'd0,  64'h0,          8'h06},  // disable
      '{C_ERS, 8'd64, 64'hFFFF_FFFF_FFFF_FFFF, 8'h07}   // erase while off
   };

   logic tck = 1'b0, rst_n = 1'b0, tdi = 1'b0;
   logic capture_ir = 1'b0, shift_ir = 1'b0, update_ir = 1'b0;
   logic capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
   logic tdo;
   int   n_chk = 0, n_bad = 0;

   always #2.5 tck = ~tck;

   isc_flash_ctrl #(
      .BANK0_SECTORS(B0), .BANK1_SECTORS(B1), .BUSY_CYCLES(BUSY),
      .ID_VALUE(IDV), .OPT_RESET(ORST)
   ) u_dut (
      .tck(tck), .rst_n(rst_n), .tdi(tdi), .tdo(tdo),
      .capture_ir(capture_ir), .shift_ir(shift_ir), .update_ir(update_ir),
      .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic scan_ir(input logic [7:0] op);
      @(negedge tck); capture_ir = 1'b1;
      @(negedge tck); capture_ir = 1'b0; shift_ir = 1'b1;
      for (int i = 0; i < 8; i++) begin
         tdi = op[i];
         @(negedge tck);
      end
      shift_ir = 1'b0; update_ir = 1'b1;
      @(negedge tck); update_ir = 1'b0;
   endtask

   task automatic scan_dr(input logic [63:0] din, input int len, output logic [63:0] dout);
      dout = '0;
      @(negedge tck); capture_dr = 1'b1;
      @(negedge tck); capture_dr = 1'b0; shift_dr = 1'b1;
      for (int i = 0; i < len; i++) begin
         tdi = din[i];
         dout[i] = tdo;
         @(negedge tck);
      end
      shift_dr = 1'b0; update_dr = 1'b1;
      @(negedge tck); update_dr = 1'b0;
   endtask

   task automatic read_status(output logic [7:0] st);
      logic [63:0] d;
      scan_ir(C_STS);
      scan_dr(64'h0, 8, d);
      st = d[7:0];
   endtask

   task automatic wait_ready(output logic [7:0] st);
      st = '0;
      for (int k = 0; k < 200; k++) begin
         read_status(st);
         if (st[2]) break;
      end
   endtask

   task automatic cmd(input logic [7:0] op, input int len, input logic [63:0] data,
                      output logic [7:0] st);
      logic [63:0] d;
      scan_ir(op);
      if (len != 0) scan_dr(data, len, d);
      wait_ready(st);
   endtask

   task automatic blank(input logic [63:0] mask, output logic [63:0] res);
      logic [63:0] d;
      scan_ir(C_BLK);
      scan_dr(mask, 64, d);
      scan_dr(64'h0, 64, res);
   endtask

   task automatic read_cfg(output logic [63:0] res);
      scan_ir(C_CFG);
      scan_dr(64'h0, 64, res);
   endtask

   initial begin
      logic [7:0]  st;
      logic [63:0] d;
      repeat (3) @(negedge tck);
      rst_n = 1'b1;

      // R1: reset state, IDCODE selected without an IR scan
      scan_dr(64'h0, 32, d);
      check("R1 idcode after reset", d, {32'h0, IDV});
      read_status(st);
      check("R1 reset status", {56'h0, st}, 64'h04);

      // R2 command table
      for (int v = 0; v < 10; v++) begin
         cmd(VEC[v].op, int'(VEC[v].len), VEC[v].data, st);
         check($sformatf("R2 table step %0d", v), {56'h0, st}, {56'h0, VEC[v].exp});
      end

      // R3: the erase issued while off changed nothing; R4 re-enable
      cmd(C_EN, 0, 64'h0, st);
      check("R4 enable status", {56'h0, st}, 64'h0E);
      blank(SMAP, d);
      check("R3 array untouched while off (R13 blank result)", d, 64'h2);

      // R6 program a high-bank sector (mask position 34)
      cmd(C_ADR, 8, 64'h22, st);
      cmd(C_PRG, 64, 64'hDEAD, st);
      check("R6 program high bank status", {56'h0, st}, 64'h0E);
      blank(SMAP, d);
      check("R6 two sectors not blank", d, 64'h4_0000_0002);
      blank(64'h4_0000_0000, d);
      check("R13 partial mask result", d, 64'h4_0000_0000);

      // R7 erase low sector 1 only
      cmd(C_ERS, 64, 64'h2, st);
      check("R7 erase status", {56'h0, st}, 64'h0E);
      blank(SMAP, d);
      check("R7 only sector 1 erased", d, 64'h4_0000_0000);

      // R10 program options: bit 63, protect position 34, flag bit 50
      cmd(C_ADR, 8, 64'h50, st);
      cmd(C_PRG, 64, 64'h8004_0004_0000_0000, st);
      read_cfg(d);
      check("R10 option readback", d, 64'h8004_0004_0000_0000);

      // R8 protected sector rejects erase and program
      cmd(C_ERS, 64, 64'h4_0000_0000, st);
      check("R8 erase protected status", {56'h0, st}, 64'h0D);
      cmd(C_ADR, 8, 64'h22, st);
      cmd(C_PRG, 64, 64'h0, st);
      check("R8 program protected status", {56'h0, st}, 64'h0D);
      blank(SMAP, d);
      check("R8 protected sector unchanged", d, 64'h4_0000_0000);

      // R10 option write without bit 63 is refused
      cmd(C_ADR, 8, 64'h50, st);
      cmd(C_PRG, 64, 64'h1, st);
      check("R10 missing bit 63 status", {56'h0, st}, 64'h0D);
      read_cfg(d);
      check("R10 options kept", d, 64'h8004_0004_0000_0000);

      // R11 option-only erase
      cmd(C_ERS, 64, 64'h0002_0000_0000_0000, st);
      check("R11 option erase status", {56'h0, st}, 64'h0E);
      read_cfg(d);
      check("R11 options reset", d, ORST);
      blank(SMAP, d);
      check("R11 sectors untouched", d, 64'h4_0000_0000);

      // R9 second program while first still busy
      cmd(C_ADR, 8, 64'h0, st);
      scan_ir(C_PRG);
      scan_dr(64'h77, 64, d);
      scan_dr(64'h88, 64, d);
      read_status(st);
      check("R9 busy rejection (R6 ready low)", {56'h0, st}, 64'h19);
      wait_ready(st);
      check("R9 int_err kept after completion", {56'h0, st}, 64'h1E);
      cmd(C_CLR, 0, 64'h0, st);
      check("R5 clear status", {56'h0, st}, 64'h0C);
      blank(SMAP, d);
      check("R9 first program took effect", d, 64'h4_0000_0001);

      // R12 protect sector 0, lock, then full erase overrides both
      cmd(C_ADR, 8, 64'h50, st);
      cmd(C_PRG, 64, 64'h8000_0000_0000_0001, st);
      cmd(C_ADR, 8, 64'h80, st);
      cmd(C_SEC, 0, 64'h0, st);
      check("R12 lock set", {56'h0, st}, 64'h4E);
      cmd(C_ERS, 64, 64'hFFFF_FFFF_FFFF_FFFF, st);
      check("R12 full erase status", {56'h0, st}, 64'h0E);
      blank(SMAP, d);
      check("R12 all sectors blank", d, 64'h0);
      read_cfg(d);
      check("R12 options reset", d, ORST);

      // R4 disable, R1 IDCODE still readable while off, R5 status unchanged
      cmd(C_DIS, 0, 64'h0, st);
      check("R4 disable status", {56'h0, st}, 64'h06);
      scan_ir(C_ID);
      scan_dr(64'h0, 32, d);
      check("R1 idcode while off", d, {32'h0, IDV});
      read_status(st);
      check("R5 idcode leaves status", {56'h0, st}, 64'h06);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(5.0 * 150000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule